// File: doc/BRIEF.md
# Dual-Mode Digital AGC Loop

This block scales a wide complex I/Q sample stream into a narrower output word and closes a gain loop around the result. It is meant to sit behind an interpolating filter and in front of a rake-style demodulator, so that a signal with a large dynamic range fits in a few output bits. The gain is a log-domain code. Its upper bits select a coarse left shift. Its lower bits select a fine multiplier between 1 and almost 2. Over the whole code range the gain spans about 96 dB, which is 16 bits of shift.

The block accumulates the power of its own outputs over a period of 2^n samples, where n is programmable. At the end of each period it forms an error and moves the gain code by the loop gain times that error. In level mode the error is the programmed target minus the log2 of the mean output power. In clip mode the error is the target minus the number of outputs in the period that saturated. Level mode therefore holds the average level, and clip mode holds the clipping rate.

A small write-only register port sets the target, loop gain, averaging length, mode and bypass, and can force the gain code to any value. In bypass the input passes through at unity weight and the loop is frozen.

Top module: `dagc_loop`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `gain_o` equals the INIT_GAIN parameter (default 128). The register defaults are: target 400, loop gain 16, averaging exponent 3, level mode, bypass off.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The output registers take the sample presented with `in_valid`.
- R3: Outside bypass, let s = gain[7:4] and f = gain[3:0]. Each lane outputs floor((x·(16+f)·2^s + 2^11) / 2^12), using the gain code in force on the cycle the input is presented.
- R4: A lane result above +32767 or below −32767 is replaced by +32767 or −32767 respectively, so −32768 never appears outside bypass.
- R5: Writing bit 0 of the control register (address 3) turns bypass on. In bypass each lane outputs bits [23:8] of its input. The measurement period is cleared, and the gain code does not change unless the gain-load register is written.
- R6: A period ends on the 2^n-th valid output counted outside bypass, where n is taken from address 2. The gain code changes only in the cycle after a period ends or after a gain-load write.
- R7: In level mode (control bit 1 = 0), the measure is L = 16·e + the 4 bits below the leading one of the mean power. The mean power is the sum of I²+Q² over the period, shifted right by n. In L, e is the position of that leading one, and L = 0 for zero power. The error is target − L, with the target at address 0.
- R8: At the end of a period the gain becomes gain + floor(error · k / 64), clamped to the range 0 to 255, where k is the loop gain at address 1.
- R9: In clip mode (control bit 1 = 1), the error is target minus the count of outputs in the period in which either lane saturated.
- R10: A write to address 4 loads bits [7:0] of the write data into the gain code on the next cycle. This load takes priority over a period-end update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 24 | In-phase input, signed |
| in_q | input | 24 | Quadrature input, signed |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Quadrature output, signed |
| gain_o | output | 8 | Current gain code, for downstream rescaling |

## Verification
The assertions assume that the input lanes and register writes are known values on every active edge. They also assume that register writes may arrive at any cycle, including mid-period and in the same cycle as a period end. The stimulus drives defined values on every cycle, including idle ones. It changes configuration between bursts and sometimes forces a gain load while a period is still running, so the load-priority and mid-period cases occur under the same assumptions. Averaging exponents stay small (0 to 4) so that many periods complete.

// File: rtl/dagc_pkg.sv
package dagc_pkg;

    // gain code: upper SHIFT_W bits coarse shift, lower FRAC_W bits fine step
    localparam int FRAC_W   = 4;
    localparam int SHIFT_W  = 4;
    localparam int GAIN_W   = FRAC_W + SHIFT_W;
    localparam int GAIN_MAX = (1 << GAIN_W) - 1;

    localparam int TGT_W    = 16;
    localparam int KG_W     = 8;
    localparam int KG_SH    = 6;
    localparam int AVG_W    = 4;
    localparam int CNT_W    = 1 << AVG_W;
    localparam int CLIP_W   = CNT_W + 1;
    localparam int ERR_W    = TGT_W + 2;
    localparam int PROD_W   = ERR_W + KG_W + 1;
    localparam int SUM_W    = PROD_W + 1;
    localparam int REG_W    = 16;

    localparam logic [2:0] REG_TARGET = 3'd0;
    localparam logic [2:0] REG_KGAIN  = 3'd1;
    localparam logic [2:0] REG_AVG    = 3'd2;
    localparam logic [2:0] REG_CTRL   = 3'd3;
    localparam logic [2:0] REG_LOAD   = 3'd4;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_CLIP  = 1'b1
    } agc_mode_e;

    typedef struct packed {
        logic [TGT_W-1:0] target;
        logic [KG_W-1:0]  kgain;
        logic [AVG_W-1:0] avg_log2;
        agc_mode_e        mode;
        logic             bypass;
    } agc_cfg_t;

    function automatic logic [GAIN_W-1:0] clamp_gain(input logic signed [SUM_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > SUM_W'(GAIN_MAX))
            return GAIN_W'(GAIN_MAX);
        else
            return v[GAIN_W-1:0];
    endfunction

endpackage

// File: rtl/dagc_lane.sv
module dagc_lane
    import dagc_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int OUT_W = 16,
    parameter int RS    = 12
) (
    input  logic signed [IN_W-1:0]  x,
    input  logic        [GAIN_W-1:0] gain,
    input  logic                    bypass,
    output logic signed [OUT_W-1:0] y,
    output logic                    sat
);
    localparam int PW = IN_W + FRAC_W + 2 + (1 << SHIFT_W);
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (RS - 1);
    localparam logic signed [PW-1:0] MAXP = PW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINP = -MAXP;

    logic signed [PW-1:0] prod, shifted, rounded, scaled;
    logic                 hi, lo;

    always_comb begin
        prod    = PW'(x) * PW'($signed({1'b0, 1'b1, gain[FRAC_W-1:0]}));
        shifted = prod <<< gain[GAIN_W-1:FRAC_W];
        rounded = shifted + HALF;
        scaled  = rounded >>> RS;
        hi      = scaled > MAXP;
        lo      = scaled < MINP;
        if (bypass)
            y = x[IN_W-1 -: OUT_W];
        else if (hi)
            y = MAXP[OUT_W-1:0];
        else if (lo)
            y = MINP[OUT_W-1:0];
        else
            y = scaled[OUT_W-1:0];
        sat = !bypass && (hi || lo);
    end

endmodule

// File: rtl/dagc_meter.sv
module dagc_meter
    import dagc_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [OUT_W-1:0] smp_i,
    input  logic signed [OUT_W-1:0] smp_q,
    input  logic                    smp_sat,
    input  logic [AVG_W-1:0]        avg_log2,
    input  logic                    bypass,
    output logic                    done,
    output logic [$clog2(2*OUT_W)+FRAC_W-1:0] log_pow,
    output logic [CLIP_W-1:0]       clip_tot
);
    localparam int POW_W = 2 * OUT_W;
    localparam int EXP_W = $clog2(POW_W);
    localparam int ACC_W = POW_W + CNT_W;

    logic [CNT_W-1:0]        cnt;
    logic [ACC_W-1:0]        acc, acc_tot;
    logic [CLIP_W-1:0]       clip;
    logic signed [POW_W-1:0] sq_i, sq_q;
    logic [POW_W-1:0]        pow, mean, norm;
    logic [CNT_W:0]          span;
    logic [EXP_W-1:0]        msb;
    logic                    last;

    always_comb begin
        sq_i     = POW_W'(smp_i) * POW_W'(smp_i);
        sq_q     = POW_W'(smp_q) * POW_W'(smp_q);
        pow      = $unsigned(sq_i) + $unsigned(sq_q);
        acc_tot  = acc + ACC_W'(pow);
        clip_tot = clip + CLIP_W'(smp_sat);
        span     = (CNT_W+1)'(1) << avg_log2;
        last     = {1'b0, cnt} >= (span - (CNT_W+1)'(1));
        done     = smp_valid && !bypass && last;
        mean     = POW_W'(acc_tot >> avg_log2);
        msb      = '0;
        for (int b = 0; b < POW_W; b++)
            if (mean[b]) msb = EXP_W'(b);
        norm     = mean << (POW_W - 1 - int'(msb));
        log_pow  = (mean == '0) ? '0 : {msb, norm[POW_W-2 -: FRAC_W]};
    end

    always_ff @(posedge clk) begin
        if (rst || bypass) begin
            cnt  <= '0;
            acc  <= '0;
            clip <= '0;
        end else if (smp_valid) begin
            if (last) begin
                cnt  <= '0;
                acc  <= '0;
                clip <= '0;
            end else begin
                cnt  <= cnt + CNT_W'(1);
                acc  <= acc_tot;
                clip <= clip_tot;
            end
        end
    end

    // R9
    clip_le_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        clip <= CLIP_W'(cnt));

    // R5
    bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (cnt == '0) && (clip == '0));

endmodule

// File: rtl/dagc_gain_ctrl.sv
module dagc_gain_ctrl
    import dagc_pkg::*;
#(
    parameter int LOG_W     = 9,
    parameter int INIT_GAIN = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  agc_cfg_t          cfg,
    input  logic              done,
    input  logic [LOG_W-1:0]  log_pow,
    input  logic [CLIP_W-1:0] clip_tot,
    input  logic              load,
    input  logic [GAIN_W-1:0] load_val,
    output logic [GAIN_W-1:0] gain
);
    logic [ERR_W-1:0]         meas;
    logic signed [ERR_W-1:0]  err;
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  delta, sum;
    logic [GAIN_W-1:0]        nxt;

    always_comb begin
        meas  = (cfg.mode == MODE_CLIP) ? ERR_W'(clip_tot) : ERR_W'(log_pow);
        err   = $signed(ERR_W'(cfg.target)) - $signed(meas);
        prod  = PROD_W'(err) * PROD_W'($signed({1'b0, cfg.kgain}));
        delta = SUM_W'(prod >>> KG_SH);
        sum   = $signed(SUM_W'(gain)) + delta;
        nxt   = clamp_gain(sum);
    end

    always_ff @(posedge clk) begin
        if (rst)
            gain <= GAIN_W'(INIT_GAIN);
        else if (load)
            gain <= load_val;
        else if (done)
            gain <= nxt;
    end

    // R6
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(done || load) |=> $stable(gain));

    // R5
    bypass_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.bypass && !load |=> $stable(gain));

    // R8
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        done && !load && !err[ERR_W-1] |=> gain >= $past(gain));

    // R10
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> gain == $past(load_val));

endmodule

// File: rtl/dagc_loop.sv
module dagc_loop
    import dagc_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter int OUT_W     = 16,
    parameter int RS        = 12,
    parameter int INIT_GAIN = 128
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic [GAIN_W-1:0]       gain_o
);
    localparam int LOG_W = $clog2(2 * OUT_W) + FRAC_W;
    localparam int LANES = 2;
    localparam logic signed [OUT_W-1:0] MINO = {1'b1, {(OUT_W-1){1'b0}}};

    agc_cfg_t                cfg;
    logic                    load;
    logic signed [IN_W-1:0]  lane_x [LANES];
    logic signed [OUT_W-1:0] lane_y [LANES];
    logic [LANES-1:0]        lane_sat;
    logic                    sat_q;
    logic                    done;
    logic [LOG_W-1:0]        log_pow;
    logic [CLIP_W-1:0]       clip_tot;

    assign load      = cfg_we && (cfg_addr == REG_LOAD);
    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.target   <= TGT_W'(400);
            cfg.kgain    <= KG_W'(16);
            cfg.avg_log2 <= AVG_W'(3);
            cfg.mode     <= MODE_LEVEL;
            cfg.bypass   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_TARGET: cfg.target   <= cfg_wdata[TGT_W-1:0];
                REG_KGAIN:  cfg.kgain    <= cfg_wdata[KG_W-1:0];
                REG_AVG:    cfg.avg_log2 <= cfg_wdata[AVG_W-1:0];
                REG_CTRL: begin
                    cfg.bypass <= cfg_wdata[0];
                    cfg.mode   <= agc_mode_e'(cfg_wdata[1]);
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dagc_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .RS(RS)) u_lane (
            .x      (lane_x[g]),
            .gain   (gain_o),
            .bypass (cfg.bypass),
            .y      (lane_y[g]),
            .sat    (lane_sat[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            sat_q     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= lane_y[0];
                out_q <= lane_y[1];
                sat_q <= |lane_sat;
            end
        end
    end

    dagc_meter #(.OUT_W(OUT_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (out_valid),
        .smp_i     (out_i),
        .smp_q     (out_q),
        .smp_sat   (sat_q),
        .avg_log2  (cfg.avg_log2),
        .bypass    (cfg.bypass),
        .done      (done),
        .log_pow   (log_pow),
        .clip_tot  (clip_tot)
    );

    dagc_gain_ctrl #(.LOG_W(LOG_W), .INIT_GAIN(INIT_GAIN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .done     (done),
        .log_pow  (log_pow),
        .clip_tot (clip_tot),
        .load     (load),
        .load_val (cfg_wdata[GAIN_W-1:0]),
        .gain     (gain_o)
    );

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !cfg.bypass |=> (out_i != MINO) && (out_q != MINO));

endmodule

// File: tb/test_dagc_loop.sv
module test_dagc_loop;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_i = '0, in_q = '0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_addr = '0;
    logic [15:0]        cfg_wdata = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;
    logic [7:0]         gain_o;

    int n_chk = 0;
    int n_bad = 0;
    bit running = 0;

    always #2 clk = ~clk;

    dagc_loop i_dagc_loop (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .gain_o(gain_o)
    );

    // ---------------- reference functions ----------------
    function automatic longint f_scale(input longint x, input int g, output bit s);
        longint v;
        v = x * (16 + (g & 15));
        v = v <<< (g >> 4);
        v = (v + 2048) >>> 12;
        s = 0;
        if (v > 32767) begin v = 32767; s = 1; end
        if (v < -32767) begin v = -32767; s = 1; end
        return v;
    endfunction

    function automatic int f_log(input longint m);
        int e;
        if (m == 0) return 0;
        e = 0;
        for (int b = 0; b < 32; b++) if (((m >> b) & 1) == 1) e = b;
        return e * 16 + int'(((m << (31 - e)) >> 27) & 15);
    endfunction

    function automatic int f_clamp(input longint v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return int'(v);
    endfunction

    // ---------------- cycle model ----------------
    int     m_tgt, m_k, m_avg, m_mode, m_byp, m_gain;
    bit     m_ov, m_osat;
    longint m_oi, m_oq, m_acc;
    int     m_cnt, m_clip;
    string  m_otag, m_gtag;

    always @(posedge clk) begin
        bit     s1, s2, dn;
        longint ni, nq, at, mean;
        int     ct, err, ng;
        if (rst) begin
            m_tgt = 400; m_k = 16; m_avg = 3; m_mode = 0; m_byp = 0;
            m_gain = 128; m_ov = 0; m_oi = 0; m_oq = 0; m_osat = 0;
            m_acc = 0; m_cnt = 0; m_clip = 0; m_otag = "R3"; m_gtag = "R1";
        end else begin
            ni = m_oi; nq = m_oq; s1 = 0; s2 = 0;
            if (in_valid) begin
                if (m_byp != 0) begin
                    ni = longint'(in_i) >>> 8;
                    nq = longint'(in_q) >>> 8;
                end else begin
                    ni = f_scale(longint'(in_i), m_gain, s1);
                    nq = f_scale(longint'(in_q), m_gain, s2);
                end
            end
            dn = 0; ng = m_gain;
            if (m_byp != 0) begin
                m_acc = 0; m_cnt = 0; m_clip = 0;
            end else if (m_ov) begin
                at = m_acc + m_oi * m_oi + m_oq * m_oq;
                ct = m_clip + int'(m_osat);
                if (m_cnt >= (1 << m_avg) - 1) begin
                    dn = 1;
                    mean = at >> m_avg;
                    err = (m_mode != 0) ? m_tgt - ct : m_tgt - f_log(mean);
                    ng = f_clamp(longint'(m_gain) + ((longint'(err) * m_k) >>> 6));
                    m_acc = 0; m_cnt = 0; m_clip = 0;
                end else begin
                    m_acc = at; m_cnt = m_cnt + 1; m_clip = ct;
                end
            end
            if (cfg_we && cfg_addr == 3'd4) begin
                m_gain = int'(cfg_wdata[7:0]); m_gtag = "R10";
            end else if (dn) begin
                m_gain = ng; m_gtag = (m_mode != 0) ? "R9" : "R7/R8";
            end else if (m_byp != 0) begin
                m_gtag = "R5";
            end else begin
                m_gtag = "R6";
            end
            if (in_valid)
                m_otag = (m_byp != 0) ? "R5" : ((s1 || s2) ? "R4" : "R3");
            m_ov = in_valid;
            if (in_valid) begin m_oi = ni; m_oq = nq; m_osat = s1 || s2; end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_tgt = int'(cfg_wdata);
                    3'd1: m_k = int'(cfg_wdata[7:0]);
                    3'd2: m_avg = int'(cfg_wdata[3:0]);
                    3'd3: begin m_byp = int'(cfg_wdata[0]); m_mode = int'(cfg_wdata[1]); end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk(out_valid == m_ov, "R2", longint'(out_valid), longint'(m_ov));
            if (m_ov) begin
                chk(longint'(out_i) == m_oi, m_otag, longint'(out_i), m_oi);
                chk(longint'(out_q) == m_oq, m_otag, longint'(out_q), m_oq);
            end
            chk(int'(gain_o) == m_gain, m_gtag, longint'(gain_o), longint'(m_gain));
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic signed [23:0] rs(input int a);
        int v;
        v = int'($urandom);
        return 24'(v >>> (32 - a));
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic feed(input int n, input int a, input int dens);
        for (int c = 0; c < n; c++) begin
            in_valid = ($urandom_range(3, 0) < dens);
            in_i = rs(a);
            in_q = rs(a);
            if ($urandom_range(15, 0) == 0) in_i = 24'sh800000;
            if ($urandom_range(15, 0) == 0) in_q = 24'sh7FFFFF;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        chk(gain_o == 8'd128, "R1", longint'(gain_o), 128);
        rst = 1'b0;
        running = 1;
        @(negedge clk);
        // R5: bypass with extreme inputs
        wr(3'd3, 16'h0001);
        feed(40, 24, 4);
        wr(3'd3, 16'h0000);
        // R4: maximum gain, large inputs saturate symmetrically
        wr(3'd4, 16'd255);
        feed(30, 24, 4);
        // R8: clamp at top, then bottom
        wr(3'd2, 16'd0);
        wr(3'd1, 16'd255);
        wr(3'd0, 16'hFFFF);
        wr(3'd4, 16'd0);
        feed(30, 8, 4);
        wr(3'd0, 16'd0);
        feed(30, 20, 4);
        // R9: clip mode regulation
        wr(3'd3, 16'h0002);
        wr(3'd0, 16'd2);
        wr(3'd1, 16'd32);
        wr(3'd2, 16'd3);
        wr(3'd4, 16'd255);
        feed(120, 22, 3);
        // R10 with a period in flight, then random bursts
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'd400);
        for (int b = 0; b < 1500; b++) begin
            case ($urandom_range(7, 0))
                0: wr(3'd0, ($urandom_range(2, 0) == 0) ? 16'($urandom_range(6, 0))
                                                        : 16'($urandom_range(520, 150)));
                1: wr(3'd1, 16'($urandom_range(63, 0)));
                2: wr(3'd2, 16'($urandom_range(4, 0)));
                3: wr(3'd3, 16'({($urandom_range(2, 0) == 0), ($urandom_range(7, 0) == 0)}));
                4: wr(3'd4, 16'($urandom_range(255, 0)));
                default: ;
            endcase
            feed($urandom_range(30, 1), $urandom_range(24, 4), $urandom_range(4, 1));
        end
        repeat (3) @(negedge clk);
        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule